// File: doc/BRIEF.md
# Microsecond Alarm Timer with Single-Shot and Auto-Reload Modes

The block counts down on a shared one-microsecond tick enable and raises a level, active-high interrupt when the count runs out. Software arms it by writing one control word. That word carries a run bit, a repeat bit and a 29-bit count. The count is written as the wanted interval minus one, so a programmed value N fires on the (N+1)-th tick after arming. In single-shot mode the timer drops back to idle when it fires. In repeat mode it reloads the programmed count and keeps going. The interrupt stays pending until software writes a clear bit into a second register. Disabling the timer does not clear it.

Control is a three-state machine. The states are IDLE, ONESHOT and PERIODIC. Its transitions are:
- arm-oneshot and arm-periodic: a control write with the run bit set, from any state.
- stop: a control write with the run bit clear, from any state, back to IDLE.
- expire-oneshot: ONESHOT to IDLE when a tick meets a zero count.
- reload: PERIODIC to itself on the same condition.

A control write while running re-arms the timer from the new value.

Top module: `usec_alarm_timer`

## Requirements
- R1: After reset the interrupt is low, and reads of the control word (address 0x0) and the status word (address 0x4) both return zero.
- R2: A control write with bit 31 = 1 and bit 30 = 0 and count field bits [28:0] = N arms single-shot mode. The interrupt goes high in the cycle after the (N+1)-th tick and not before.
- R3: In single-shot mode the run bit (control read bit 31) reads 0 after expiry. The remaining count stays 0. Further ticks raise no new interrupt.
- R4: With bit 30 = 1 the timer fires every N+1 ticks. After k ticks the remaining count is N minus (k mod (N+1)), and the run bit stays 1.
- R5: A control write with bit 31 = 0 stops the timer. Later ticks change neither the remaining count nor the interrupt, and the run bit reads 0.
- R6: Writing the status word at address 0x4 with bit 30 = 1 clears the pending interrupt. A status write with bit 30 = 0 has no effect.
- R7: A pending interrupt stays high after the timer is stopped, until it is cleared.
- R8: A control write while the timer is running restarts the countdown from the newly written count.
- R9: When a clear write and an expiry fall in the same cycle, the interrupt stays set.
- R10: When a control write and a tick fall in the same cycle, the write wins. The remaining count equals the written count and is not decremented in that cycle.
- R11: A status read returns the pending flag in bit 30 and the remaining count in bits [28:0]. A control read returns the run state in bit 31, the stored repeat bit in bit 30, 0 in bit 29, and the programmed count in bits [28:0]. Without a tick the count does not change.
- R12: Writes to any address other than 0x0 and 0x4 are ignored, and reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle microsecond tick enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Byte address for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Pending interrupt, level, active high |

## Verification
Two pairs of events can fall in the same cycle. The first is an expiry (a tick meeting a zero count) and a software clear of the pending flag. The bench lines up a clear write with the tick that empties a count of 1. It judges that the interrupt is still high afterwards, and that a later plain clear drops it. The second pair is a tick and a control write. The bench drives both in one cycle and requires the remaining count to equal the new value exactly, with no decrement.

// File: rtl/usat_pkg.sv
package usat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ONESHOT  = 2'd1,
        ST_PERIODIC = 2'd2
    } usat_state_e;

    localparam int unsigned RUN_BIT   = 31;
    localparam int unsigned REP_BIT   = 30;
    localparam int unsigned CLR_BIT   = 30;
    localparam int unsigned PEND_BIT  = 30;
endpackage

// File: rtl/usat_regif.sv
module usat_regif #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CNT_W    = 29,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CTRL_OFS = 0,
    parameter int unsigned STAT_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              running,
    input  logic              pending,
    input  logic [CNT_W-1:0]  remaining,
    output logic              ctrl_wr,
    output logic              ctrl_run,
    output logic              ctrl_rep,
    output logic [CNT_W-1:0]  ctrl_cnt,
    output logic              stat_clr,
    output logic [CNT_W-1:0]  reload_cnt,
    output logic [DATA_W-1:0] reg_rdata
);
    import usat_pkg::*;

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic             ctrl_hit;
    logic             stat_hit;
    logic             rep_q;
    logic [CNT_W-1:0] cnt_cfg_q;
    logic             unused_wbits;

    assign ctrl_hit = reg_wr && (reg_addr == CTRL_A);
    assign stat_hit = reg_wr && (reg_addr == STAT_A);

    assign ctrl_wr  = ctrl_hit;
    assign ctrl_run = reg_wdata[RUN_BIT];
    assign ctrl_rep = reg_wdata[REP_BIT];
    assign ctrl_cnt = reg_wdata[CNT_W-1:0];
    assign stat_clr = stat_hit && reg_wdata[CLR_BIT];

    assign unused_wbits = ^reg_wdata[REP_BIT-1:CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_q     <= 1'b0;
            cnt_cfg_q <= '0;
        end else if (ctrl_hit) begin
            rep_q     <= reg_wdata[REP_BIT];
            cnt_cfg_q <= reg_wdata[CNT_W-1:0];
        end
    end

    assign reload_cnt = cnt_cfg_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_A) begin
            reg_rdata[RUN_BIT]   = running;
            reg_rdata[REP_BIT]   = rep_q;
            reg_rdata[CNT_W-1:0] = cnt_cfg_q;
        end else if (reg_addr == STAT_A) begin
            reg_rdata[PEND_BIT]  = pending;
            reg_rdata[CNT_W-1:0] = remaining;
        end
    end
endmodule

// File: rtl/usat_ctrl_fsm.sv
module usat_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_run,
    input  logic ctrl_rep,
    input  logic tick,
    input  logic cnt_zero,
    output logic running,
    output logic rep_running,
    output logic dec,
    output logic expire,
    output logic reload
);
    import usat_pkg::*;

    usat_state_e state_q;
    usat_state_e state_d;
    usat_state_e arm_target;

    always_comb begin
        if (!ctrl_run) arm_target = ST_IDLE;
        else if (ctrl_rep) arm_target = ST_PERIODIC;
        else arm_target = ST_ONESHOT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr) state_d = arm_target;
            end
            ST_ONESHOT: begin
                if (ctrl_wr)                state_d = arm_target;
                else if (tick && cnt_zero)  state_d = ST_IDLE;
            end
            ST_PERIODIC: begin
                if (ctrl_wr) state_d = arm_target;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running     = 1'b0;
        rep_running = 1'b0;
        dec         = 1'b0;
        expire      = 1'b0;
        reload      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ONESHOT: begin
                running = 1'b1;
                dec     = tick && !cnt_zero && !ctrl_wr;
                expire  = tick && cnt_zero && !ctrl_wr;
            end
            ST_PERIODIC: begin
                running     = 1'b1;
                rep_running = 1'b1;
                dec         = tick && !cnt_zero && !ctrl_wr;
                expire      = tick && cnt_zero && !ctrl_wr;
                reload      = expire;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/usat_counter.sv
module usat_counter #(
    parameter int unsigned CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load)   cnt_q <= load_val;
        else if (dec)    cnt_q <= cnt_q - CNT_W'(1);
        else if (reload) cnt_q <= reload_val;
    end

    assign cnt      = cnt_q;
    assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/usat_irq_latch.sv
module usat_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pending
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (set) pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
    end

    assign pending = pend_q;
endmodule

// File: rtl/usec_alarm_timer.sv
module usec_alarm_timer #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CNT_W    = 29,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned CTRL_OFS = 0,
    parameter int unsigned STAT_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_us,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic             ctrl_wr_w;
    logic             ctrl_run_w;
    logic             ctrl_rep_w;
    logic [CNT_W-1:0] ctrl_cnt_w;
    logic             stat_clr_w;
    logic [CNT_W-1:0] reload_cnt_w;
    logic             run_w;
    logic             rep_run_w;
    logic             dec_w;
    logic             expire_w;
    logic             reload_w;
    logic [CNT_W-1:0] cnt_w;
    logic             zero_w;
    logic             pend_w;

    usat_regif #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
        .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
    ) regif_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .running(run_w), .pending(pend_w), .remaining(cnt_w),
        .ctrl_wr(ctrl_wr_w), .ctrl_run(ctrl_run_w), .ctrl_rep(ctrl_rep_w),
        .ctrl_cnt(ctrl_cnt_w), .stat_clr(stat_clr_w),
        .reload_cnt(reload_cnt_w), .reg_rdata(reg_rdata)
    );

    usat_ctrl_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr_w), .ctrl_run(ctrl_run_w), .ctrl_rep(ctrl_rep_w),
        .tick(tick_us), .cnt_zero(zero_w),
        .running(run_w), .rep_running(rep_run_w),
        .dec(dec_w), .expire(expire_w), .reload(reload_w)
    );

    usat_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n),
        .load(ctrl_wr_w), .load_val(ctrl_cnt_w),
        .dec(dec_w), .reload(reload_w), .reload_val(reload_cnt_w),
        .cnt(cnt_w), .cnt_zero(zero_w)
    );

    usat_irq_latch irq_i (
        .clk(clk), .rst_n(rst_n),
        .set(expire_w), .clr(stat_clr_w), .pending(pend_w)
    );

    assign irq = pend_w;
endmodule

// File: rtl/usat_checker.sv
module usat_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 29,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_us,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq,
    input logic              running,
    input logic              rep_running,
    input logic [CNT_W-1:0]  cnt
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);

    // R2: an interrupt only rises after a tick
    p_irq_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick_us));

    // R5: a control write with the run bit clear leaves the timer idle
    p_stop_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && !reg_wdata[31]) |=> !running);

    // R6: a clear with no tick drops the interrupt
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STAT && reg_wdata[30] && !tick_us) |=> !irq);

    // R7: pending persists without a clear
    p_pending_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && reg_addr == A_STAT && reg_wdata[30])) |=> irq);

    // R4: repeat mode keeps running until software writes the control word
    p_periodic_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_running && !(reg_wr && reg_addr == A_CTRL)) |=> (running && rep_running));

    // R11: the count holds without a tick or a write
    p_count_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_us && !reg_wr) |=> $stable(cnt));

    // R3: a single-shot run ends on the interrupt that it raises
    p_oneshot_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && !$past(rep_running) && !$past(reg_wr)) |-> !running);
endmodule

bind usec_alarm_timer usat_checker #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .irq(irq), .running(run_w), .rep_running(rep_run_w), .cnt(cnt_w)
);

// File: tb/usec_alarm_timer_tb_top.sv
`timescale 1ns/1ps
module usec_alarm_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usec_alarm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle with optional tick and optional write
    task automatic cyc(input bit t, input bit w, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        tick_us = t; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        tick_us = 1'b0; reg_wr = 1'b0;
        #1;
    endtask

    task automatic tick();
        cyc(1'b1, 1'b0, 4'h0, 32'h0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input bit run, input bit rep, input int n);
        return {run, rep, 1'b0, 29'(n)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(4'h0, r); check("R1 ctrl", r, 32'h0);
        rd(4'h4, r); check("R1 stat", r, 32'h0);

        // R2/R3 single-shot sweep
        for (int n = 0; n < 10; n++) begin
            wr(4'h0, ctl(1, 0, n));
            rd(4'h4, r); check("R11 count after arm", r, {3'b000, 29'(n)});
            for (int k = 1; k <= n + 1; k++) begin
                tick();
                check("R2 irq timing", {31'h0, irq}, {31'h0, (k == n + 1)});
                rd(4'h4, r);
                check("R11 status", r, {1'b0, (k == n + 1), 1'b0, 29'((k <= n) ? n - k : 0)});
            end
            rd(4'h0, r); check("R3 run bit cleared", r, ctl(0, 0, n));
            wr(4'h4, 32'h4000_0000);
            check("R6 clear", {31'h0, irq}, 32'h0);
            for (int k = 0; k < 3; k++) tick();
            check("R3 no refire", {31'h0, irq}, 32'h0);
            rd(4'h4, r); check("R3 count stays zero", r, 32'h0);
        end

        // R4 periodic sweep
        for (int n = 0; n < 6; n++) begin
            wr(4'h0, ctl(1, 1, n));
            for (int k = 1; k <= 3 * (n + 1); k++) begin
                tick();
                check("R4 irq period", {31'h0, irq}, {31'h0, (k % (n + 1) == 0)});
                rd(4'h4, r);
                check("R4 remaining", {3'b000, r[28:0]}, {3'b000, 29'(n - (k % (n + 1)))});
                if (irq) wr(4'h4, 32'h4000_0000);
            end
            rd(4'h0, r); check("R4 still running", r, ctl(1, 1, n));
        end

        // R5 stop
        wr(4'h0, ctl(1, 0, 5));
        tick(); tick();
        wr(4'h0, 32'h0);
        rd(4'h0, r); check("R5 ctrl after stop", r, 32'h0);
        for (int k = 0; k < 10; k++) tick();
        check("R5 no irq", {31'h0, irq}, 32'h0);
        rd(4'h4, r); check("R5 count frozen", r, 32'h0);

        // R7 pending held after stop; R6 clear bit zero ignored
        wr(4'h0, ctl(1, 0, 0));
        tick();
        check("R2 n=0 fires", {31'h0, irq}, 32'h1);
        wr(4'h0, 32'h0);
        check("R7 held after stop", {31'h0, irq}, 32'h1);
        wr(4'h4, 32'hBFFF_FFFF);
        check("R6 bit30 zero ignored", {31'h0, irq}, 32'h1);
        wr(4'h4, 32'h4000_0000);
        check("R6 clear", {31'h0, irq}, 32'h0);

        // R8 restart
        wr(4'h0, ctl(1, 0, 4));
        tick(); tick(); tick();
        wr(4'h0, ctl(1, 0, 4));
        rd(4'h4, r); check("R8 count restarted", r, 32'd4);
        for (int k = 0; k < 4; k++) tick();
        check("R8 no early irq", {31'h0, irq}, 32'h0);
        tick();
        check("R8 irq after restart", {31'h0, irq}, 32'h1);
        wr(4'h4, 32'h4000_0000);

        // R10 write and tick together
        wr(4'h0, ctl(1, 0, 6));
        tick(); tick();
        rd(4'h4, r); check("R10 before", r, 32'd4);
        cyc(1'b1, 1'b1, 4'h0, ctl(1, 0, 3));
        rd(4'h4, r); check("R10 write wins", r, 32'd3);

        // R9 clear and expiry together
        wr(4'h0, ctl(1, 0, 1));
        tick();
        cyc(1'b1, 1'b1, 4'h4, 32'h4000_0000);
        check("R9 set wins", {31'h0, irq}, 32'h1);
        wr(4'h4, 32'h4000_0000);
        check("R9 later clear", {31'h0, irq}, 32'h0);

        // R11 max count, bit 29 reads zero, no tick no change
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, r); check("R11 ctrl max", r, 32'hDFFF_FFFF);
        rd(4'h4, r); check("R11 stat max", r, 32'h1FFF_FFFF);
        repeat (5) @(negedge clk);
        #1;
        rd(4'h4, r); check("R11 no tick hold", r, 32'h1FFF_FFFF);
        tick();
        rd(4'h4, r); check("R11 one tick", r, 32'h1FFF_FFFE);

        // R12 other addresses
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hC, 32'h0);
        rd(4'h0, r); check("R12 ctrl untouched", r, 32'hDFFF_FFFF);
        rd(4'h8, r); check("R12 read zero", r, 32'h0);
        check("R12 irq untouched", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule